// File: doc/BRIEF.md
# Clock stop and power-down controller

This block produces a group of CPU-rate clock outputs, a group of PCI-rate clock outputs, one PCI-rate output that never stops, and a reference clock. All are divided from one fast sample clock. Three active-low request pins control them. The CPU stop request parks the CPU group. The PCI stop request parks the gated PCI group. The power-down request parks every output and drops the crystal and VCO enable flags. Every output is driven from a flop, and a change of state is only allowed while the underlying divided clock is low. A stopped output therefore rests low and restarts with a complete high phase.

Each request passes a two-flop synchronizer. The CPU and PCI stop requests are then captured on the rising edge of the free-running PCI clock. The CPU request runs through two further stages that advance on falling CPU edges, so its effect has a bounded delay of a few CPU periods. Power down wins over both stop requests. On entry, each output is parked at its own next falling edge, and the reference clock is parked at its own next falling edge without waiting for the others. Once every output is low, the flags drop. On exit, the flags rise first. The outputs stay low for a stabilisation count, and then every divider restarts from a low phase. Reset looks the same as leaving power down.

There is no data flowing through the block, so it has no valid/ready interface. All pins are plain levels.

Top module: `clkstop_ctrl`

## Requirements
- R1: With defaults (CPU_HALF=2, PCI_RATIO=3, REF_HALF=7), the CPU outputs have a period of 4 fast cycles and the PCI outputs (gated and free-running) a period of 12. A PCI rising edge always coincides with a CPU rising edge. The reference output has a period of 14.
- R2: Every high phase of every output lasts exactly one half period (2, 6, 6 and 7 fast cycles). Every low phase lasts at least one half period. The gating state changes only on a falling edge of the divided clock.
- R3: Each request pin passes a two-flop synchronizer. The CPU and PCI stop requests are captured on a rising edge of the free-running PCI output.
- R4: Let T be the free-running PCI rising edge that captures cpu_stop_n low. The last CPU output rise is before T + 2 CPU periods. No further CPU rises occur while the request is held, and the other outputs keep running.
- R5: Let T be the free-running PCI rising edge that captures cpu_stop_n high. The first CPU output rise falls between T + 2 and T + 3 CPU periods, inclusive.
- R6: The gated PCI output follows a request captured at free-running rise T from the next rise at T + 12 onward. The rise at T still follows the previous state, and the free-running output is unaffected.
- R7: Within 24 fast cycles of pwr_down_n going low, xtal_en_o and vco_en_o are low. Whenever they are low, all clock outputs are low.
- R8: While powered down, toggling either stop request causes no rising edge on any output. After power down has begun, no gated enable re-opens until the block has woken up.
- R9: After power down is released, the flags rise at cycle W. The first free-running PCI rise comes exactly STAB_CYC + 6 fast cycles after W. The stop request levels present at wake take effect from the first pulse: a CPU stop held through wake keeps the CPU outputs low.
- R10: While rst_n is low, all outputs and flags are low. After reset is released, the block goes through the wake sequence of R9.
- R11: All copies within the CPU group carry identical waveforms, and likewise within the gated PCI group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous request, low parks the CPU outputs |
| pci_stop_n | input | 1 | Asynchronous request, low parks the gated PCI outputs |
| pwr_down_n | input | 1 | Asynchronous request, low enters power down |
| cpu_clk_o | output | N_CPU | Gated CPU-rate clocks |
| pci_clk_o | output | N_PCI | Gated PCI-rate clocks |
| pci_free_o | output | 1 | PCI-rate clock, stopped only in power down |
| ref_clk_o | output | 1 | Reference clock, stopped only in power down |
| xtal_en_o | output | 1 | Crystal enable flag |
| vco_en_o | output | 1 | VCO enable flag |

## Verification
A gate that changed while its divided clock was high would show up within one half period as a short or stretched high phase on that output. A stuck or skipped stage in the CPU request pipeline would move the first missing or first restored CPU edge outside the window of two to three periods, measured from the capturing PCI edge. A power-down state machine that stalled in its drain state would leave the flags high past the 24-cycle bound. One that left early would drop the flags while an output could still rise. A wrong wake count would shift the first free-running PCI edge away from its exact cycle.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_WAKE  = 2'd1,
    PM_RUN   = 2'd2,
    PM_DRAIN = 2'd3
  } pm_state_e;
endpackage

// File: rtl/clkstop_sync2.sv
module clkstop_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/clkstop_div.sv
module clkstop_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic adv_i,
  output logic ph_q,
  output logic ph_n,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          last;

  assign last   = (cnt_q == CW'(HALF - 1));
  assign tick_o = adv_i & last & ~hold_i;
  assign ph_n   = hold_i ? 1'b0 : (ph_q ^ tick_o);

  always_comb begin
    if (hold_i)     cnt_n = '0;
    else if (adv_i) cnt_n = last ? '0 : cnt_q + CW'(1);
    else            cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU     = 4,
  parameter int N_PCI     = 7,
  parameter int CPU_HALF  = 2,
  parameter int PCI_RATIO = 3,
  parameter int REF_HALF  = 7,
  parameter int STAB_CYC  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_down_n,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_o,
  output logic             ref_clk_o,
  output logic             xtal_en_o,
  output logic             vco_en_o
);
  localparam int STAB_W = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;

  logic [2:0] req_sync;
  logic       cpu_go, pci_go, pd_act;

  clkstop_sync2 #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cpu_stop_n, pci_stop_n, pwr_down_n}),
    .q_o   (req_sync)
  );

  assign cpu_go = req_sync[2];
  assign pci_go = req_sync[1];
  assign pd_act = ~req_sync[0];

  pm_state_e          state_q, state_n;
  logic [STAB_W-1:0]  stab_q, stab_n;
  logic               hold;

  assign hold = (state_q == PM_OFF) || (state_q == PM_WAKE);

  logic cpu_ph_q, cpu_ph_n, cpu_tick;
  logic pci_ph_q, pci_ph_n, pci_tick;
  logic ref_ph_q, ref_ph_n, ref_tick;

  clkstop_div #(.HALF(CPU_HALF)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .adv_i(1'b1),
    .ph_q(cpu_ph_q), .ph_n(cpu_ph_n), .tick_o(cpu_tick)
  );

  clkstop_div #(.HALF(PCI_RATIO)) u_pci_div (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .adv_i(cpu_tick),
    .ph_q(pci_ph_q), .ph_n(pci_ph_n), .tick_o(pci_tick)
  );

  clkstop_div #(.HALF(REF_HALF)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .adv_i(1'b1),
    .ph_q(ref_ph_q), .ph_n(ref_ph_n), .tick_o(ref_tick)
  );

  logic cpu_fall, pci_rise, pci_fall, ref_fall;
  assign cpu_fall = cpu_tick &  cpu_ph_q;
  assign pci_rise = pci_tick & ~pci_ph_q;
  assign pci_fall = pci_tick &  pci_ph_q;
  assign ref_fall = ref_tick &  ref_ph_q;

  logic cpu_req_q, cpu_s1_q, cpu_en_q, pci_req_q, pci_en_q, free_en_q, ref_en_q;
  logic cpu_req_n, cpu_s1_n, cpu_en_n, pci_req_n, pci_en_n, free_en_n, ref_en_n;

  always_comb begin
    state_n   = state_q;
    stab_n    = stab_q;
    cpu_req_n = cpu_req_q;
    cpu_s1_n  = cpu_s1_q;
    cpu_en_n  = cpu_en_q;
    pci_req_n = pci_req_q;
    pci_en_n  = pci_en_q;
    free_en_n = free_en_q;
    ref_en_n  = ref_en_q;
    case (state_q)
      PM_RUN: begin
        if (pci_rise) begin
          cpu_req_n = cpu_go;
          pci_req_n = pci_go;
        end
        if (cpu_fall) begin
          cpu_s1_n = cpu_req_q;
          cpu_en_n = cpu_s1_q;
        end
        if (pci_fall) pci_en_n = pci_req_q;
        if (pd_act)   state_n  = PM_DRAIN;
      end
      PM_DRAIN: begin
        if (cpu_fall) cpu_en_n = 1'b0;
        if (pci_fall) begin
          pci_en_n  = 1'b0;
          free_en_n = 1'b0;
        end
        if (ref_fall) ref_en_n = 1'b0;
        if (!cpu_en_q && !pci_en_q && !free_en_q && !ref_en_q) state_n = PM_OFF;
      end
      PM_OFF: begin
        if (!pd_act) begin
          state_n = PM_WAKE;
          stab_n  = '0;
        end
      end
      default: begin
        cpu_req_n = cpu_go;
        cpu_s1_n  = cpu_go;
        cpu_en_n  = cpu_go;
        pci_req_n = pci_go;
        pci_en_n  = pci_go;
        free_en_n = 1'b1;
        ref_en_n  = 1'b1;
        if (pd_act)                                  state_n = PM_OFF;
        else if (stab_q == STAB_W'(STAB_CYC - 1))    state_n = PM_RUN;
        else                                         stab_n  = stab_q + STAB_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PM_OFF;
      stab_q    <= '0;
      cpu_req_q <= 1'b0;
      cpu_s1_q  <= 1'b0;
      cpu_en_q  <= 1'b0;
      pci_req_q <= 1'b0;
      pci_en_q  <= 1'b0;
      free_en_q <= 1'b0;
      ref_en_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      stab_q    <= stab_n;
      cpu_req_q <= cpu_req_n;
      cpu_s1_q  <= cpu_s1_n;
      cpu_en_q  <= cpu_en_n;
      pci_req_q <= pci_req_n;
      pci_en_q  <= pci_en_n;
      free_en_q <= free_en_n;
      ref_en_q  <= ref_en_n;
    end
  end

  for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_clk_o[gi] <= 1'b0;
      else        cpu_clk_o[gi] <= cpu_ph_n & cpu_en_n;
    end
  end

  for (genvar gj = 0; gj < N_PCI; gj++) begin : g_pci_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pci_clk_o[gj] <= 1'b0;
      else        pci_clk_o[gj] <= pci_ph_n & pci_en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_free_o <= 1'b0;
      ref_clk_o  <= 1'b0;
    end else begin
      pci_free_o <= pci_ph_n & free_en_n;
      ref_clk_o  <= ref_ph_n & ref_en_n;
    end
  end

  assign xtal_en_o = (state_q != PM_OFF);
  assign vco_en_o  = (state_q != PM_OFF);

  // R2
  cpu_gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_en_q) |-> ($fell(cpu_ph_q) || $past(hold)));

  // R2
  pci_gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pci_en_q) |-> ($fell(pci_ph_q) || $past(hold)));

  // R3
  cpu_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cpu_req_q) && $past(state_q == PM_RUN)) |-> $past(pci_rise));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en_o |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o && !ref_clk_o));

  // R8
  drain_no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DRAIN) |=> (!$rose(cpu_en_q) && !$rose(pci_en_q) && !$rose(ref_en_q)));

  // R9
  wake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE) |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o && !ref_clk_o));
endmodule

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
  localparam int N_CPU   = 4;
  localparam int N_PCI   = 7;
  localparam int CPU_PER = 4;
  localparam int PCI_PER = 12;
  localparam int STAB    = 64;
  localparam int HALF_EXP [4] = '{2, 6, 6, 7};
  // bits: [3] cpu_stop_n, [2] pci_stop_n, [1] CPU group expected running, [0] PCI group expected running
  localparam logic [3:0] VEC [6] = '{4'b1111, 4'b0101, 4'b0000, 4'b1010, 4'b1111, 4'b0000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_down_n = 1'b1;
  logic [N_CPU-1:0] cpu_clk_o;
  logic [N_PCI-1:0] pci_clk_o;
  logic pci_free_o, ref_clk_o, xtal_en_o, vco_en_o;

  clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .STAB_CYC(STAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_down_n(pwr_down_n), .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
    .pci_free_o(pci_free_o), .ref_clk_o(ref_clk_o), .xtal_en_o(xtal_en_o), .vco_en_o(vco_en_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // index 0 cpu, 1 gated pci, 2 free pci, 3 ref
  logic [3:0] prev = '0;
  int rise_t [4] = '{-1000, -1000, -1000, -1000};
  int fall_t [4] = '{-1000, -1000, -1000, -1000};
  bit rise_ok [4] = '{0, 0, 0, 0};
  int rise_cnt [4] = '{0, 0, 0, 0};

  always @(negedge clk) begin
    logic [3:0] now;
    now = {ref_clk_o, pci_free_o, pci_clk_o[0], cpu_clk_o[0]};
    if (!rst_n) begin
      prev = '0;
      for (int k = 0; k < 4; k++) rise_ok[k] = 1'b0;
    end else begin
      if (cpu_clk_o != {N_CPU{cpu_clk_o[0]}} || pci_clk_o != {N_PCI{pci_clk_o[0]}})
        chk(1'b0, "R11", "group copies differ", int'(cpu_clk_o), int'({N_CPU{cpu_clk_o[0]}}));
      for (int k = 0; k < 4; k++) begin
        if (now[k] && !prev[k]) begin
          chk((cyc - fall_t[k]) >= HALF_EXP[k], "R2", $sformatf("low width out%0d", k),
              cyc - fall_t[k], HALF_EXP[k]);
          rise_t[k] = cyc;
          rise_ok[k] = 1'b1;
        end else if (!now[k] && prev[k]) begin
          if (rise_ok[k])
            chk((cyc - rise_t[k]) == HALF_EXP[k], "R2", $sformatf("high width out%0d", k),
                cyc - rise_t[k], HALF_EXP[k]);
          fall_t[k] = cyc;
        end
      end
      for (int k = 0; k < 4; k++) if (now[k] && !prev[k]) rise_cnt[k]++;
      prev = now;
    end
  end

  task automatic wait_free_rise(output int t);
    int n;
    n = rise_cnt[2];
    wait (rise_cnt[2] != n);
    #1;
    t = rise_t[2];
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int t, t0, w, n0, n2, d0, d1, d2, d3, tot;
    wait_cyc(5);
    // R10 reset state
    chk({cpu_clk_o, pci_clk_o, pci_free_o, ref_clk_o} == '0, "R10", "outputs in reset", 1, 0);
    chk({xtal_en_o, vco_en_o} == 2'b00, "R10", "flags in reset", int'({xtal_en_o, vco_en_o}), 0);
    rst_n = 1'b1;
    while (!xtal_en_o) @(negedge clk);
    w = cyc;
    n0 = rise_cnt[0];
    wait (rise_cnt[0] != n0);
    chk(rise_t[0] == w + STAB + 2, "R10", "first cpu rise after reset", rise_t[0] - w, STAB + 2);
    wait_free_rise(t);
    chk(t == w + STAB + 6, "R9", "first free rise after reset", t - w, STAB + 6);

    // R1 R4 R6 R11 vector table
    foreach (VEC[i]) begin
      @(negedge clk);
      cpu_stop_n = VEC[i][3];
      pci_stop_n = VEC[i][2];
      wait_cyc(6 * PCI_PER);
      d0 = rise_cnt[0]; d1 = rise_cnt[1]; d2 = rise_cnt[2]; d3 = rise_cnt[3];
      wait_cyc(2 * PCI_PER);
      d0 = rise_cnt[0] - d0; d1 = rise_cnt[1] - d1; d2 = rise_cnt[2] - d2; d3 = rise_cnt[3] - d3;
      chk(d0 == (VEC[i][1] ? 6 : 0), "R4", $sformatf("vec%0d cpu rises", i), d0, VEC[i][1] ? 6 : 0);
      chk(d1 == (VEC[i][0] ? 2 : 0), "R6", $sformatf("vec%0d pci rises", i), d1, VEC[i][0] ? 2 : 0);
      chk(d2 == 2, "R1", $sformatf("vec%0d free rises", i), d2, 2);
      chk(d3 >= 1, "R1", $sformatf("vec%0d ref rises", i), d3, 1);
      chk(cpu_clk_o == {N_CPU{cpu_clk_o[0]}} && pci_clk_o == {N_PCI{pci_clk_o[0]}},
          "R11", $sformatf("vec%0d copies equal", i), 0, 0);
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    wait_cyc(6 * PCI_PER);

    // R4 CPU stop latency
    wait_free_rise(t);
    cpu_stop_n = 1'b0;
    wait_free_rise(t);
    wait_cyc(3 * CPU_PER);
    chk(rise_t[0] < t + 2 * CPU_PER, "R4", "last cpu rise offset", rise_t[0] - t, 2 * CPU_PER - 1);
    n0 = rise_cnt[0]; n2 = rise_cnt[2];
    wait_cyc(5 * CPU_PER);
    chk(rise_cnt[0] == n0, "R4", "cpu stays parked", rise_cnt[0] - n0, 0);
    chk(rise_cnt[2] > n2, "R4", "free pci keeps running", rise_cnt[2] - n2, 1);
    // R5 CPU restart latency
    wait_free_rise(t);
    cpu_stop_n = 1'b1;
    wait_free_rise(t);
    n0 = rise_cnt[0];
    wait (rise_cnt[0] != n0);
    chk(rise_t[0] - t >= 2 * CPU_PER && rise_t[0] - t <= 3 * CPU_PER, "R5",
        "cpu restart offset", rise_t[0] - t, 2 * CPU_PER);

    // R6 PCI stop and start
    wait_free_rise(t);
    pci_stop_n = 1'b0;
    wait_free_rise(t);
    chk(rise_t[1] == t, "R6", "gated pci rise at capture edge", rise_t[1] - t, 0);
    wait_cyc(PCI_PER + 2);
    chk(rise_t[1] == t, "R6", "no gated pci rise after capture", rise_t[1] - t, 0);
    chk(rise_t[2] == t + PCI_PER, "R6", "free pci unaffected", rise_t[2] - t, PCI_PER);
    wait_free_rise(t);
    pci_stop_n = 1'b1;
    wait_free_rise(t);
    chk(rise_t[1] < t, "R6", "no gated pci rise at restart capture", rise_t[1] - t, -1);
    wait_cyc(PCI_PER + 2);
    chk(rise_t[1] == t + PCI_PER, "R6", "gated pci restart offset", rise_t[1] - t, PCI_PER);

    // R7 power down entry
    wait_free_rise(t);
    wait_cyc(3);
    pwr_down_n = 1'b0;
    t0 = cyc;
    while (xtal_en_o && (cyc - t0) < 40) @(negedge clk);
    chk((cyc - t0) <= 24, "R7", "flag drop latency", cyc - t0, 24);
    chk({xtal_en_o, vco_en_o} == 2'b00, "R7", "flags low", int'({xtal_en_o, vco_en_o}), 0);
    chk({cpu_clk_o, pci_clk_o, pci_free_o, ref_clk_o} == '0, "R7", "outputs parked", 1, 0);
    // R8 stop requests ignored in power down
    tot = rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3];
    for (int i = 0; i < 6; i++) begin
      cpu_stop_n = i[0];
      pci_stop_n = ~i[1];
      wait_cyc(10);
    end
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b1;
    wait_cyc(10);
    chk(rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] == tot, "R8", "rises during power down",
        rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] - tot, 0);
    chk(!xtal_en_o, "R8", "flags stay low", int'(xtal_en_o), 0);

    // R9 wake with CPU stop held
    n0 = rise_cnt[0];
    pwr_down_n = 1'b1;
    while (!xtal_en_o) @(negedge clk);
    w = cyc;
    chk(vco_en_o, "R9", "vco flag with crystal flag", int'(vco_en_o), 1);
    wait_free_rise(t);
    chk(t - w == STAB + 6, "R9", "first free rise after wake", t - w, STAB + 6);
    chk(rise_t[1] == t, "R9", "gated pci starts with free pci", rise_t[1] - t, 0);
    wait_cyc(4 * PCI_PER);
    chk(rise_cnt[0] == n0, "R9", "cpu held by stop through wake", rise_cnt[0] - n0, 0);
    cpu_stop_n = 1'b1;
    wait_cyc(6 * PCI_PER);
    chk(rise_cnt[0] > n0, "R5", "cpu resumes after release", rise_cnt[0] - n0, 1);

    // R10 reset during run
    rst_n = 1'b0;
    @(negedge clk);
    chk({cpu_clk_o, pci_clk_o, pci_free_o, ref_clk_o, xtal_en_o, vco_en_o} == '0, "R10",
        "mid-run reset clears", 1, 0);
    wait_cyc(3);
    rst_n = 1'b1;
    while (!xtal_en_o) @(negedge clk);
    w = cyc;
    wait_free_rise(t);
    chk(t - w == STAB + 6, "R10", "wake after mid-run reset", t - w, STAB + 6);
    wait_cyc(4 * PCI_PER);
    finish_run();
  end
endmodule